// File: doc/BRIEF.md
# Burst-of-Four Quad-Rate SRAM Core

This block models, cycle for cycle, a static RAM with separate read and write data paths and four-word bursts. One system clock stands in for both phases of the double-rate clock. The two words that move on the rising and falling halves of a period travel together on a double-width bus, with the earlier word in the low half. The address bus is time-shared in the same way. Its low slot is the value seen in the first half-period and serves the read port. Its high slot is the value seen in the second half-period and serves the write port.

Each address picks a group of four consecutive words. A burst moves words 0 and 1 in one period and words 2 and 3 in the next, so each port can start a new burst at most every other period. The two ports are fully independent and can each run a burst in the same period. Writes are committed to the array internally after their second half arrives. Until that commit, the pending burst is forwarded to any read of the same group, so reads always see the newest contents. Byte-lane write enables allow partial word updates. A free-running strobe toggles every period, so a receiver can use it to capture the read data.

Top module: `qdrb4_sram`

## Requirements
- R1: While reset is held and on the first sample after it is released, `rvalid` is 0, `rdata` is all zeros and `echo` is 0.
- R2: A read is accepted on a clock edge where `rd_sel_n` is 0 and the read port did not accept a read on the previous edge. Its group address is taken from `adr_pair[GRP_AW-1:0]`.
- R3: For a read accepted on edge e, words 0 and 1 of the group appear on `rdata` after edge e+RD_LAT (word 0 in bits [WORD_W-1:0]). Words 2 and 3 appear after edge e+RD_LAT+1. `rvalid` is 1 exactly in those periods, and `rdata` is all zeros whenever `rvalid` is 0.
- R4: A write is accepted on an edge where `wr_sel_n` is 0 and the write port did not accept a write on the previous edge. Its group comes from `adr_pair[2*GRP_AW-1:GRP_AW]`. `wdata` carries words 0 and 1 on the accepting edge and words 2 and 3 on the next edge, with the lower word in the low half.
- R5: Each word has L = 1 lane for widths up to 9 bits and WORD_W/9 lanes otherwise, each WORD_W/L bits wide. Bit j*L+l of `wbe_n` is the enable for lane l of the j-th word of the current pair. A 0 writes that lane. A 1 leaves the lane's stored bits unchanged.
- R6: A select held low on the edge right after its port accepted a transfer is ignored. It changes neither the read output nor the array contents.
- R7: A read returns the effect of every write accepted on the same edge or earlier, including writes not yet committed. A write accepted on a later edge does not affect it.
- R8: A read and a write may be accepted on the same edge, to the same group or to different groups.
- R9: After reset, `echo` inverts on every clock edge.
- R10: While a port's select is high, the values on its address slot (and, for writes, on `wdata` and `wbe_n`) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one period per beat pair |
| rst_n | input | 1 | Asynchronous active-low reset |
| adr_pair | input | 2*GRP_AW | Shared address bus; low slot read group, high slot write group |
| rd_sel_n | input | 1 | Active-low read-port select |
| wr_sel_n | input | 1 | Active-low write-port select |
| wdata | input | 2*WORD_W | Write beat pair, earlier word low |
| wbe_n | input | 2*L | Active-low byte-lane write enables for the beat pair |
| rdata | output | 2*WORD_W | Read beat pair, earlier word low |
| rvalid | output | 1 | High during the two periods of a read burst |
| echo | output | 1 | Strobe that toggles every period |

## Verification
The bench builds the core with 18-bit words, which gives two byte lanes, a 3-bit group address (eight groups, 32 words) and a read latency of two. This is small enough to fill and read back every group, to sweep lane-enable patterns across all groups, and to run a long stretch of dense random traffic over the whole array. In that traffic, reads often land on a group whose write is still pending, and selects often arrive while their port is busy. The expected value of every read is derived from an arithmetic reference array in the bench that is updated beat pair by beat pair.

// File: rtl/qdrb4_pkg.sv
package qdrb4_pkg;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_HALF = 2'd1,
        WS_FULL = 2'd2
    } wstage_e;

    // byte lanes per word: one lane up to 9 bits, otherwise 9-bit lanes
    function automatic int lane_count(input int w);
        return (w <= 9) ? 1 : w / 9;
    endfunction

endpackage

// File: rtl/qdrb4_store.sv
module qdrb4_store #(
    parameter int W  = 18,
    parameter int AW = 4,
    parameter int NL = 2
) (
    input  logic              clk,
    input  logic [AW-1:0]     rd_grp,
    input  logic              rd_half,
    output logic [2*W-1:0]    rd_pair,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_grp,
    input  logic [4*W-1:0]    wr_data,
    input  logic [4*NL-1:0]   wr_be
);
    localparam int NG = 1 << AW;
    localparam int LW = W / NL;

    logic [W-1:0] mem [NG*4];

    // lane k of the burst belongs to word k/NL, lane k%NL
    always_ff @(posedge clk) begin
        for (int k = 0; k < 4*NL; k++) begin
            if (wr_en && wr_be[k]) begin
                mem[{wr_grp, 2'(k / NL)}][(k % NL)*LW +: LW] <= wr_data[k*LW +: LW];
            end
        end
    end

    assign rd_pair = {mem[{rd_grp, rd_half, 1'b1}], mem[{rd_grp, rd_half, 1'b0}]};

endmodule

// File: rtl/qdrb4_wr_path.sv
module qdrb4_wr_path import qdrb4_pkg::*; #(
    parameter int W  = 18,
    parameter int AW = 4,
    parameter int NL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic [AW-1:0]     grp_in,
    input  logic [2*W-1:0]    beat_pair,
    input  logic [2*NL-1:0]   lane_off,
    output logic              half_o,
    output logic              commit_o,
    output logic              pend_vld,
    output logic [AW-1:0]     pend_grp,
    output logic [4*W-1:0]    pend_data,
    output logic [4*NL-1:0]   pend_be
);
    typedef struct packed {
        wstage_e           stage;
        logic [AW-1:0]     grp;
        logic [4*W-1:0]    data;
        logic [4*NL-1:0]   be;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.stage)
            WS_HALF: begin
                st_d.stage              = WS_FULL;
                st_d.data[4*W-1:2*W]    = beat_pair;
                st_d.be[4*NL-1:2*NL]    = ~lane_off;
            end
            WS_FULL: st_d.stage = WS_IDLE;
            default: ;
        endcase
        // a new burst may start whenever the second half is not due
        if (!sel_n && st_q.stage != WS_HALF) begin
            st_d.stage            = WS_HALF;
            st_d.grp              = grp_in;
            st_d.data[2*W-1:0]    = beat_pair;
            st_d.data[4*W-1:2*W]  = '0;
            st_d.be[2*NL-1:0]     = ~lane_off;
            st_d.be[4*NL-1:2*NL]  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign half_o    = (st_q.stage == WS_HALF);
    assign commit_o  = (st_q.stage == WS_FULL);
    assign pend_vld  = (st_q.stage != WS_IDLE);
    assign pend_grp  = st_q.grp;
    assign pend_data = st_q.data;
    assign pend_be   = st_q.be;

endmodule

// File: rtl/qdrb4_rd_path.sv
module qdrb4_rd_path #(
    parameter int W   = 18,
    parameter int AW  = 4,
    parameter int NL  = 2,
    parameter int LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic [AW-1:0]     grp_in,
    output logic [AW-1:0]     fetch_grp,
    output logic              fetch_half,
    input  logic [2*W-1:0]    mem_pair,
    input  logic              pend_vld,
    input  logic [AW-1:0]     pend_grp,
    input  logic [4*W-1:0]    pend_data,
    input  logic [4*NL-1:0]   pend_be,
    output logic              first_o,
    output logic [2*W-1:0]    rdata,
    output logic              rvalid
);
    localparam int LW = W / NL;

    typedef struct packed {
        logic                      fst;
        logic                      snd;
        logic [AW-1:0]             grp;
        logic [LAT-1:0]            pv;
        logic [LAT-1:0][2*W-1:0]   pd;
    } rst_t;

    rst_t st_d, st_q;
    logic             accept, fetch_on, hit;
    logic [2*W-1:0]   src, merged;
    logic [2*NL-1:0]  ben;

    always_comb begin
        st_d     = st_q;
        accept   = !sel_n && !st_q.fst;
        fetch_on = st_q.fst | st_q.snd;

        // newest data: pending burst lanes override array lanes
        hit    = pend_vld && (pend_grp == st_q.grp);
        src    = st_q.snd ? pend_data[4*W-1:2*W] : pend_data[2*W-1:0];
        ben    = st_q.snd ? pend_be[4*NL-1:2*NL] : pend_be[2*NL-1:0];
        merged = mem_pair;
        for (int k = 0; k < 2*NL; k++) begin
            if (hit && ben[k]) merged[k*LW +: LW] = src[k*LW +: LW];
        end

        st_d.fst = accept;
        st_d.snd = st_q.fst;
        st_d.grp = accept ? grp_in : st_q.grp;

        st_d.pv[0] = fetch_on;
        st_d.pd[0] = fetch_on ? merged : '0;
        for (int i = 1; i < LAT; i++) begin
            st_d.pv[i] = st_q.pv[i-1];
            st_d.pd[i] = st_q.pd[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_grp  = st_q.grp;
    assign fetch_half = st_q.snd;
    assign first_o    = st_q.fst;
    assign rvalid     = st_q.pv[LAT-1];
    assign rdata      = st_q.pd[LAT-1];

endmodule

// File: rtl/qdrb4_sram.sv
module qdrb4_sram import qdrb4_pkg::*; #(
    parameter int WORD_W = 18,
    parameter int GRP_AW = 4,
    parameter int RD_LAT = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [2*GRP_AW-1:0]                   adr_pair,
    input  logic                                  rd_sel_n,
    input  logic                                  wr_sel_n,
    input  logic [2*WORD_W-1:0]                   wdata,
    input  logic [2*lane_count(WORD_W)-1:0]       wbe_n,
    output logic [2*WORD_W-1:0]                   rdata,
    output logic                                  rvalid,
    output logic                                  echo
);
    localparam int NL = lane_count(WORD_W);

    logic                  wr_half, wr_commit, pend_vld;
    logic [GRP_AW-1:0]     pend_grp, fetch_grp;
    logic [4*WORD_W-1:0]   pend_data;
    logic [4*NL-1:0]       pend_be;
    logic                  fetch_half, rd_first;
    logic [2*WORD_W-1:0]   mem_pair;
    logic                  echo_d, echo_q;

    qdrb4_wr_path #(.W(WORD_W), .AW(GRP_AW), .NL(NL)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (wr_sel_n),
        .grp_in    (adr_pair[2*GRP_AW-1:GRP_AW]),
        .beat_pair (wdata),
        .lane_off  (wbe_n),
        .half_o    (wr_half),
        .commit_o  (wr_commit),
        .pend_vld  (pend_vld),
        .pend_grp  (pend_grp),
        .pend_data (pend_data),
        .pend_be   (pend_be)
    );

    qdrb4_store #(.W(WORD_W), .AW(GRP_AW), .NL(NL)) u_store (
        .clk     (clk),
        .rd_grp  (fetch_grp),
        .rd_half (fetch_half),
        .rd_pair (mem_pair),
        .wr_en   (wr_commit),
        .wr_grp  (pend_grp),
        .wr_data (pend_data),
        .wr_be   (pend_be)
    );

    qdrb4_rd_path #(.W(WORD_W), .AW(GRP_AW), .NL(NL), .LAT(RD_LAT)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (rd_sel_n),
        .grp_in     (adr_pair[GRP_AW-1:0]),
        .fetch_grp  (fetch_grp),
        .fetch_half (fetch_half),
        .mem_pair   (mem_pair),
        .pend_vld   (pend_vld),
        .pend_grp   (pend_grp),
        .pend_data  (pend_data),
        .pend_be    (pend_be),
        .first_o    (rd_first),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );

    always_comb echo_d = ~echo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) echo_q <= 1'b0;
        else        echo_q <= echo_d;
    end

    assign echo = echo_q;

endmodule

// File: rtl/qdrb4_sram_chk.sv
module qdrb4_sram_chk #(
    parameter int W = 18
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2*W-1:0]  rdata,
    input logic            rvalid,
    input logic            echo,
    input logic            rd_first,
    input logic            wr_half,
    input logic            wr_commit
);
    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> rdata == '0);

    p_burst_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid) |=> rvalid);

    p_echo_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> echo != $past(echo));

    p_rd_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_first |=> !rd_first);

    p_wr_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_half |=> wr_commit);

    p_commit_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);
endmodule

bind qdrb4_sram qdrb4_sram_chk #(.W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .echo      (echo),
    .rd_first  (rd_first),
    .wr_half   (wr_half),
    .wr_commit (wr_commit)
);

// File: tb/qdrb4_sram_test.sv
`timescale 1ns/1ps
module qdrb4_sram_test;
    localparam int W   = 18;
    localparam int AW  = 3;
    localparam int LAT = 2;
    localparam int NG  = 1 << AW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2*AW-1:0] adr_pair;
    logic            rd_sel_n, wr_sel_n;
    logic [2*W-1:0]  wdata;
    logic [3:0]      wbe_n;
    logic [2*W-1:0]  rdata;
    logic            rvalid, echo;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [W-1:0]   refm [NG*4];
    logic           ev [16];
    logic [2*W-1:0] ed [16];
    logic           m_wh = 1'b0, m_rh = 1'b0;
    logic [AW-1:0]  m_wg = '0, m_rg = '0;
    logic [31:0]    rng = 32'h1ace_b00c;

    always #2 clk = ~clk;

    qdrb4_sram #(.WORD_W(W), .GRP_AW(AW), .RD_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .adr_pair(adr_pair), .rd_sel_n(rd_sel_n),
        .wr_sel_n(wr_sel_n), .wdata(wdata), .wbe_n(wbe_n),
        .rdata(rdata), .rvalid(rvalid), .echo(echo)
    );

    function automatic logic [W-1:0] pat(input int g, input int k, input int salt);
        return W'(g*4099 + k*517 + salt*131 + 33);
    endfunction

    task automatic nxt();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    // lane k of the pair: word k/2, lane k%2 (R5 layout, two 9-bit lanes)
    task automatic apply_pair(input logic [AW-1:0] g, input int base,
                              input logic [2*W-1:0] wd, input logic [3:0] bn);
        for (int k = 0; k < 4; k++) begin
            if (!bn[k]) refm[int'(g)*4 + base + k/2][(k%2)*9 +: 9] = wd[k*9 +: 9];
        end
    endtask

    task automatic snap(input logic [AW-1:0] g, input int base, input int slot);
        ev[slot] = 1'b1;
        ed[slot] = {refm[int'(g)*4 + base + 1], refm[int'(g)*4 + base]};
    endtask

    // called at a falling edge: check outputs of the last rising edge,
    // then drive the inputs for the next rising edge and update the model
    task automatic tick(input string tag, input logic rs_n, input logic ws_n,
                        input logic [AW-1:0] rg, input logic [AW-1:0] wg,
                        input logic [2*W-1:0] wd, input logic [3:0] bn);
        int s;
        s = (cyc - 1) & 15;
        total++;
        if (rvalid !== ev[s] || rdata !== ed[s]) begin
            bad++;
            $display("FAIL %s read port at edge %0d: actual valid=%0b data=%h expected valid=%0b data=%h",
                     tag, cyc, rvalid, rdata, ev[s], ed[s]);
        end
        ev[s] = 1'b0;
        ed[s] = '0;
        total++;
        if (echo !== 1'(cyc % 2)) begin
            bad++;
            $display("FAIL R9 echo at edge %0d: actual=%0b expected=%0b", cyc, echo, 1'(cyc % 2));
        end

        rd_sel_n = rs_n;
        wr_sel_n = ws_n;
        adr_pair = {wg, rg};
        wdata    = wd;
        wbe_n    = bn;

        if (m_wh) begin
            apply_pair(m_wg, 2, wd, bn);
            m_wh = 1'b0;
        end else if (!ws_n) begin
            apply_pair(wg, 0, wd, bn);
            m_wh = 1'b1;
            m_wg = wg;
        end
        if (m_rh) begin
            snap(m_rg, 2, (cyc + LAT) & 15);
            m_rh = 1'b0;
        end else if (!rs_n) begin
            snap(rg, 0, (cyc + LAT) & 15);
            m_rh = 1'b1;
            m_rg = rg;
        end

        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        nxt();
        tick(tag, 1'b1, 1'b1, rng[2:0], rng[5:3], {rng[17:0], rng[31:14]}, rng[9:6]);
    endtask

    task automatic read_all(input string tag);
        for (int g = 0; g < NG; g++) begin
            tick(tag, 1'b0, 1'b1, AW'(g), '0, '0, 4'hF);
            tick(tag, 1'b1, 1'b1, '0, '0, '0, 4'hF);
        end
        repeat (LAT + 2) idle(tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual edges=%0d expected completion before 50000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rd_sel_n = 1'b1;
        wr_sel_n = 1'b1;
        adr_pair = '0;
        wdata    = '0;
        wbe_n    = 4'hF;
        for (int i = 0; i < NG*4; i++) refm[i] = '0;
        for (int i = 0; i < 16; i++) begin
            ev[i] = 1'b0;
            ed[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: state right after reset
        repeat (3) idle("R1");

        // R4: fill every group with full bursts, one every two periods
        for (int g = 0; g < NG; g++) begin
            tick("R4", 1'b1, 1'b0, '0, AW'(g), {pat(g,1,0), pat(g,0,0)}, 4'h0);
            tick("R4", 1'b1, 1'b1, '0, '0, {pat(g,3,0), pat(g,2,0)}, 4'h0);
        end
        repeat (2) idle("R4");

        // R2 / R3: back-to-back reads of every group
        read_all("R2 R3");

        // R5: lane enable patterns, then read back
        for (int g = 0; g < NG; g++) begin
            tick("R5", 1'b1, 1'b0, '0, AW'(g), {pat(g,1,7), pat(g,0,7)}, 4'(g*3));
            tick("R5", 1'b1, 1'b1, '0, '0, {pat(g,3,7), pat(g,2,7)}, 4'(15 - g*2));
        end
        read_all("R5");

        // R8: read and write on the same edge, different groups
        for (int g = 0; g < NG; g++) begin
            tick("R8", 1'b0, 1'b0, AW'(g), AW'((g+3) % NG), {pat(g,1,2), pat(g,0,2)}, 4'h0);
            tick("R8", 1'b1, 1'b1, '0, '0, {pat(g,3,2), pat(g,2,2)}, 4'h0);
        end
        // R7 / R8: same group on the same edge: the write is visible
        for (int g = 0; g < NG; g++) begin
            tick("R7", 1'b0, 1'b0, AW'(g), AW'(g), {pat(g,1,3), pat(g,0,3)}, 4'h0);
            tick("R7", 1'b1, 1'b1, '0, '0, {pat(g,3,3), pat(g,2,3)}, 4'h0);
        end
        // R7: read one period after a write to the same group
        for (int g = 0; g < NG; g++) begin
            tick("R7", 1'b1, 1'b0, '0, AW'(g), {pat(g,1,4), pat(g,0,4)}, 4'h0);
            tick("R7", 1'b0, 1'b1, AW'(g), '0, {pat(g,3,4), pat(g,2,4)}, 4'h0);
        end
        // R7: a write one period after the read is not visible to it
        for (int g = 0; g < NG; g++) begin
            tick("R7", 1'b0, 1'b1, AW'(g), '0, '0, 4'hF);
            tick("R7", 1'b1, 1'b0, '0, AW'(g), {pat(g,1,5), pat(g,0,5)}, 4'h0);
            tick("R7", 1'b1, 1'b1, '0, '0, {pat(g,3,5), pat(g,2,5)}, 4'h0);
        end
        repeat (LAT + 2) idle("R7");

        // R6: selects held low every period; every second one is ignored
        for (int i = 0; i < 16; i++) begin
            tick("R6", 1'b0, 1'b0, AW'(i % NG), AW'((i*5) % NG), {pat(i,1,6), pat(i,0,6)}, 4'(i));
        end
        repeat (LAT + 2) idle("R6");
        read_all("R6");

        // R10: deselected ports with busy address and data lines
        repeat (24) idle("R10");
        read_all("R10");

        // R7 / R8 / R6: dense pseudo-random traffic
        for (int i = 0; i < 3000; i++) begin
            logic rs, ws;
            logic [AW-1:0] rg, wg;
            logic [3:0] bn;
            nxt();
            rs = rng[0] & rng[1];
            ws = rng[2] & rng[3];
            rg = rng[6:4];
            wg = rng[9:7];
            bn = rng[13:10] & rng[17:14];
            nxt();
            tick("R7", rs, ws, rg, wg, {rng[17:0], rng[31:14]}, bn);
        end
        repeat (LAT + 3) idle("R7");
        read_all("R7");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule